// File: doc/BRIEF.md
# SMBus Target Address Dispatcher

This block watches a two-wire SMBus/I2C bus from the system clock domain. It waits for a START condition and shifts in the first byte after it: a 7-bit address followed by the R/W# bit. When the byte is complete, it decides whether to acknowledge it. Four address classes are compared in a fixed priority order, and each class has its own enable. When the byte is acknowledged, the block raises a one-hot code naming the downstream flow that should handle the rest of the transfer:

- Host Notify
- ARP
- general-purpose register access
- generic SMBus/I2C target

The data phases after the address byte are handled elsewhere.

SCL and SDA arrive raw and pass through flop synchronizers inside the block. The only thing the block does to the bus is drive `sda_pull`, an open-drain pull-down control, during the ACK slot. All configuration inputs are plain levels and must be held steady while a transfer is in progress. The block has no data stream, so it has no valid/ready interface.

Top module: `smb_addr_dispatch`

## Requirements
- R1: After reset, `sda_pull`, `flow_sel`, `rw_bit` and `match_stb` are all 0. SCL clocking that is not preceded by a START never pulls SDA and never strobes.
- R2: When `tgt_en` is 0, every address byte is NACKed: SDA stays released and no strobe is given.
- R3: A byte of 10h selects Host Notify (`flow_sel` = 4'b0001) if `notify_en` is 1. If `notify_en` is 0, the byte is NACKed.
- R4: A byte of C2h selects ARP (`flow_sel` = 4'b0010) if `arp_en` is 1. If `arp_en` is 0, the byte is NACKed.
- R5: A byte equal to {`gp_addr`,0} selects the register flow (`flow_sel` = 4'b0100) if `gp_en` is 1. If `gp_en` is 0, the byte is NACKed.
- R6: A byte equal to {`tgt_addr0`,0} or {`tgt_addr1`,0} selects the generic target flow (`flow_sel` = 4'b1000) when the matching address's own enable is 1. If no matching address is enabled, the byte is NACKed.
- R7: A byte that matches none of the four classes is NACKed.
- R8: When `ign_rw` is 1, bit 0 of the byte is left out of every comparison, so 11h, C3h and read-direction target bytes also match. When `ign_rw` is 0, a byte with bit 0 set matches nothing.
- R9: Classes are tried in the order 10h, C2h, general-purpose address, target addresses. The first class whose address matches decides the result. If that class is disabled, the byte is NACKed even when a later class would match and is enabled.
- R10: On an ACK, `sda_pull` rises only after the SCL falling edge that follows the eighth data bit, and falls at the SCL falling edge that follows the ninth clock. `sda_pull` stays 0 while the eighth bit is clocked, and it changes only while SCL is low. On a NACK it stays 0.
- R11: At the end of the ACK clock, `flow_sel` (at most one bit set) and `rw_bit` (byte bit 0) are registered, and `match_stb` pulses for exactly one system clock.
- R12: A STOP or a repeated START aborts any byte in progress, releases `sda_pull`, and clears `flow_sel` and `rw_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| tgt_en | input | 1 | Global target-mode enable |
| notify_en | input | 1 | Enable for the Host Notify byte 10h |
| arp_en | input | 1 | Enable for the ARP byte C2h |
| gp_en | input | 1 | Enable for the general-purpose address |
| gp_addr | input | 7 | General-purpose register 7-bit address |
| tgt_addr0 | input | 7 | First target 7-bit address |
| tgt_addr0_en | input | 1 | Enable for `tgt_addr0` |
| tgt_addr1 | input | 7 | Second target 7-bit address |
| tgt_addr1_en | input | 1 | Enable for `tgt_addr1` |
| ign_rw | input | 1 | Leave bit 0 out of address comparisons |
| sda_pull | output | 1 | 1 = pull SDA low (ACK slot) |
| flow_sel | output | 4 | One-hot flow: bit0 Host Notify, bit1 ARP, bit2 register, bit3 generic target |
| rw_bit | output | 1 | Bit 0 of the acknowledged byte |
| match_stb | output | 1 | One-cycle pulse when an ACK completes |

## Verification
The bench builds the block with its default two-stage synchronizer. It drives SCL with a half period of ten system clocks, so each sampled edge lands several cycles clear of the synchronizer delay and of the ACK drive and release points. The programmable addresses are fixed at 30h, 50h and 22h, distinct from the two fixed bytes. This lets every class be hit and disabled one at a time. In a directed case the general-purpose address is then moved onto 08h, which aliases the Host Notify byte, to expose the priority rule. A further directed case uses repeated START and mid-byte STOP to reach the abort paths.

// File: rtl/smb_disp_pkg.sv
package smb_disp_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = BYTE_W - 1;
  localparam int NUM_FLOWS = 4;
  localparam int NUM_TGT   = 2;

  localparam logic [BYTE_W-1:0] NOTIFY_BYTE = 8'h10;
  localparam logic [BYTE_W-1:0] ARP_BYTE    = 8'hC2;

  localparam int FLOW_NOTIFY = 0;
  localparam int FLOW_ARP    = 1;
  localparam int FLOW_GPREG  = 2;
  localparam int FLOW_TARGET = 3;

  typedef logic [NUM_FLOWS-1:0] flow_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_DECIDE,
    ST_DRIVE,
    ST_TAIL,
    ST_HOLD
  } frame_st_e;
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_prev;
  logic              sda_prev;

  // Idle bus is high: reset every stage to 1 so no false event follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_in};
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
  import smb_disp_pkg::*;
#(
  parameter int N_TGT = NUM_TGT
) (
  input  logic [BYTE_W-1:0]            addr_byte,
  input  logic                         ign_rw,
  input  logic                         tgt_en,
  input  logic                         notify_en,
  input  logic                         arp_en,
  input  logic                         gp_en,
  input  logic [ADDR_W-1:0]            gp_addr,
  input  logic [N_TGT-1:0][ADDR_W-1:0] tgt_addr,
  input  logic [N_TGT-1:0]             tgt_addr_en,
  output logic                         ack_ok,
  output flow_t                        flow_code
);
  logic [BYTE_W-1:0] cmp_mask;
  logic              is_notify;
  logic              is_arp;
  logic              is_gp;
  logic [N_TGT-1:0]  tgt_seen;
  logic [N_TGT-1:0]  tgt_live;

  assign cmp_mask  = {{ADDR_W{1'b1}}, ~ign_rw};
  assign is_notify = ((addr_byte ^ NOTIFY_BYTE) & cmp_mask) == '0;
  assign is_arp    = ((addr_byte ^ ARP_BYTE) & cmp_mask) == '0;
  assign is_gp     = ((addr_byte ^ {gp_addr, 1'b0}) & cmp_mask) == '0;

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    assign tgt_seen[i] = ((addr_byte ^ {tgt_addr[i], 1'b0}) & cmp_mask) == '0;
    assign tgt_live[i] = tgt_seen[i] & tgt_addr_en[i];
  end

  // Fixed priority: the first class whose address matches owns the decision.
  always_comb begin
    ack_ok    = 1'b0;
    flow_code = '0;
    if (!tgt_en) begin
      ack_ok = 1'b0;
    end else if (is_notify) begin
      ack_ok                 = notify_en;
      flow_code[FLOW_NOTIFY] = notify_en;
    end else if (is_arp) begin
      ack_ok              = arp_en;
      flow_code[FLOW_ARP] = arp_en;
    end else if (is_gp) begin
      ack_ok                = gp_en;
      flow_code[FLOW_GPREG] = gp_en;
    end else if (|tgt_seen) begin
      ack_ok                 = |tgt_live;
      flow_code[FLOW_TARGET] = |tgt_live;
    end
  end
endmodule

// File: rtl/smb_addr_frame.sv
module smb_addr_frame
  import smb_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              ack_ok,
  input  flow_t             flow_code,
  output logic [BYTE_W-1:0] addr_byte,
  output logic              sda_pull,
  output flow_t             flow_sel,
  output logic              rw_bit,
  output logic              match_stb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_e        state;
  logic [CNT_W-1:0] bit_cnt;
  flow_t            flow_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      addr_byte <= '0;
      flow_pend <= '0;
      sda_pull  <= 1'b0;
      flow_sel  <= '0;
      rw_bit    <= 1'b0;
      match_stb <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      if (start_evt || stop_evt) begin
        state    <= start_evt ? ST_SHIFT : ST_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        flow_sel <= '0;
        rw_bit   <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: if (scl_rise) begin
            addr_byte <= {addr_byte[BYTE_W-2:0], sda_lvl};
            bit_cnt   <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) state <= ST_DECIDE;
          end
          ST_DECIDE: if (scl_fall) begin
            if (ack_ok) begin
              sda_pull  <= 1'b1;
              flow_pend <= flow_code;
              state     <= ST_DRIVE;
            end else begin
              state <= ST_HOLD;
            end
          end
          ST_DRIVE: if (scl_rise) state <= ST_TAIL;
          ST_TAIL: if (scl_fall) begin
            sda_pull  <= 1'b0;
            flow_sel  <= flow_pend;
            rw_bit    <= addr_byte[0];
            match_stb <= 1'b1;
            state     <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_addr_dispatch.sv
module smb_addr_dispatch
  import smb_disp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 tgt_en,
  input  logic                 notify_en,
  input  logic                 arp_en,
  input  logic                 gp_en,
  input  logic [ADDR_W-1:0]    gp_addr,
  input  logic [ADDR_W-1:0]    tgt_addr0,
  input  logic                 tgt_addr0_en,
  input  logic [ADDR_W-1:0]    tgt_addr1,
  input  logic                 tgt_addr1_en,
  input  logic                 ign_rw,
  output logic                 sda_pull,
  output logic [NUM_FLOWS-1:0] flow_sel,
  output logic                 rw_bit,
  output logic                 match_stb
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic ack_ok;
  flow_t flow_code;
  logic [BYTE_W-1:0] addr_byte;
  logic [NUM_TGT-1:0][ADDR_W-1:0] tgt_addr_arr;
  logic [NUM_TGT-1:0] tgt_en_arr;

  assign tgt_addr_arr = {tgt_addr1, tgt_addr0};
  assign tgt_en_arr   = {tgt_addr1_en, tgt_addr0_en};

  smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_addr_match #(.N_TGT(NUM_TGT)) u_match (
    .addr_byte(addr_byte), .ign_rw(ign_rw), .tgt_en(tgt_en),
    .notify_en(notify_en), .arp_en(arp_en), .gp_en(gp_en),
    .gp_addr(gp_addr), .tgt_addr(tgt_addr_arr), .tgt_addr_en(tgt_en_arr),
    .ack_ok(ack_ok), .flow_code(flow_code)
  );

  smb_addr_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .ack_ok(ack_ok), .flow_code(flow_code), .addr_byte(addr_byte),
    .sda_pull(sda_pull), .flow_sel(flow_sel), .rw_bit(rw_bit),
    .match_stb(match_stb)
  );
endmodule

// File: rtl/smb_addr_dispatch_chk.sv
module smb_addr_dispatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_en,
  input logic       sda_pull,
  input logic [3:0] flow_sel,
  input logic       match_stb,
  input logic       scl_lvl,
  input logic       start_evt,
  input logic       stop_evt
);
  p_flow_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flow_sel));

  p_stb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |=> !match_stb);

  p_stb_flow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> $countones(flow_sel) == 1);

  p_disabled_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> tgt_en);

  p_abort_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> (flow_sel == 4'b0) && !sda_pull);

  p_pull_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  p_pull_fall_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && !$past(stop_evt) && !$past(start_evt)) |-> !scl_lvl);
endmodule

bind smb_addr_dispatch smb_addr_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_en(tgt_en), .sda_pull(sda_pull),
  .flow_sel(flow_sel), .match_stb(match_stb), .scl_lvl(scl_lvl),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/smb_addr_dispatch_test.sv
module smb_addr_dispatch_test;
  localparam int H = 10;
  localparam int NVEC = 16;
  // {byte, cfg{tgt,notify,arp,gp,t0,t1,ign}, ack, flow}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h10, 7'b1111110, 1'b1, 4'b0001},  // R3
    {8'h10, 7'b1011110, 1'b0, 4'b0000},  // R3 disabled
    {8'hC2, 7'b1111110, 1'b1, 4'b0010},  // R4
    {8'hC2, 7'b1101110, 1'b0, 4'b0000},  // R4 disabled
    {8'h60, 7'b1111110, 1'b1, 4'b0100},  // R5
    {8'h60, 7'b1110110, 1'b0, 4'b0000},  // R5 disabled
    {8'hA0, 7'b1111110, 1'b1, 4'b1000},  // R6 addr0
    {8'h44, 7'b1111110, 1'b1, 4'b1000},  // R6 addr1
    {8'hA0, 7'b1111010, 1'b0, 4'b0000},  // R6 addr0 off
    {8'h44, 7'b1111100, 1'b0, 4'b0000},  // R6 addr1 off
    {8'h55, 7'b1111110, 1'b0, 4'b0000},  // R7
    {8'h10, 7'b0111110, 1'b0, 4'b0000},  // R2
    {8'h11, 7'b1111110, 1'b0, 4'b0000},  // R8 no ignore
    {8'h11, 7'b1111111, 1'b1, 4'b0001},  // R8
    {8'hC3, 7'b1111111, 1'b1, 4'b0010},  // R8
    {8'hA1, 7'b1111111, 1'b1, 4'b1000}   // R8
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic tgt_en, notify_en, arp_en, gp_en, tgt_addr0_en, tgt_addr1_en, ign_rw;
  logic [6:0] gp_addr, tgt_addr0, tgt_addr1;
  logic sda_pull, rw_bit, match_stb;
  logic [3:0] flow_sel;
  logic sda_line;
  int errors = 0, checks = 0, stb_cnt = 0, pull_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  smb_addr_dispatch uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .tgt_en(tgt_en), .notify_en(notify_en), .arp_en(arp_en), .gp_en(gp_en),
    .gp_addr(gp_addr), .tgt_addr0(tgt_addr0), .tgt_addr0_en(tgt_addr0_en),
    .tgt_addr1(tgt_addr1), .tgt_addr1_en(tgt_addr1_en), .ign_rw(ign_rw),
    .sda_pull(sda_pull), .flow_sel(flow_sel), .rw_bit(rw_bit),
    .match_stb(match_stb)
  );

  always @(negedge clk) begin
    if (match_stb) stb_cnt++;
    if (sda_pull) pull_seen++;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(logic [6:0] c);
    {tgt_en, notify_en, arp_en, gp_en, tgt_addr0_en, tgt_addr1_en, ign_rw} = c;
  endtask

  task automatic bus_start();
    sda_m = 1; wt(H); scl_m = 1; wt(H);
    sda_m = 0; wt(H); scl_m = 0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wt(H); scl_m = 1; wt(H); scl_m = 0; wt(2);
  endtask

  // Sends START + byte + ACK clock; returns whether SDA was low mid ACK-high.
  task automatic send_addr(logic [7:0] b, output logic got_ack);
    stb_cnt = 0; pull_seen = 0;
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1; wt(H);
      if (i == 0) chk("R10", "pull before 8th fall", int'(sda_pull), 0);
      scl_m = 0; wt(2);
    end
    sda_m = 1; wt(H); scl_m = 1; wt(H / 2);
    got_ack = !sda_line;
    wt(H / 2); scl_m = 0; wt(H);
  endtask

  initial begin
    gp_addr = 7'h30; tgt_addr0 = 7'h50; tgt_addr1 = 7'h22;
    set_cfg(7'b1111110);
    wt(5); rst_n = 1; wt(5);
    chk("R1", "reset pull", int'(sda_pull), 0);
    chk("R1", "reset flow", int'(flow_sel), 0);
    chk("R1", "reset rw", int'(rw_bit), 0);
    chk("R1", "reset stb", int'(match_stb), 0);

    // R1: clocking without a START
    stb_cnt = 0; pull_seen = 0;
    scl_m = 0; wt(H); sda_m = 0;
    for (int i = 0; i < 9; i++) begin
      wt(H); scl_m = 1; wt(H); scl_m = 0;
    end
    wt(H); sda_m = 1; wt(H); scl_m = 1; wt(H);
    chk("R1", "no-start pull", pull_seen, 0);
    chk("R1", "no-start stb", stb_cnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      automatic logic [19:0] e = VEC[v];
      automatic logic a;
      set_cfg(e[11:5]);
      send_addr(e[19:12], a);
      chk("R2/R3/R4/R5/R6/R7/R8", $sformatf("vec %0d ack", v), int'(a), int'(e[4]));
      chk("R11", $sformatf("vec %0d flow", v), int'(flow_sel), int'(e[3:0]));
      chk("R11", $sformatf("vec %0d stb", v), stb_cnt, int'(e[4]));
      if (e[4]) chk("R11", $sformatf("vec %0d rw", v), int'(rw_bit), int'(e[12]));
      chk("R10", $sformatf("vec %0d release", v), int'(sda_pull), 0);
      if (!e[4]) chk("R10", $sformatf("vec %0d nack pull", v), pull_seen, 0);
      bus_stop();
      chk("R12", $sformatf("vec %0d stop clear", v), int'(flow_sel), 0);
    end

    // R9: gp address aliases 10h; disabled notify blocks the lower class
    begin
      automatic logic a;
      gp_addr = 7'h08; set_cfg(7'b1011110);
      send_addr(8'h10, a);
      chk("R9", "alias nack", int'(a), 0);
      chk("R9", "alias flow", int'(flow_sel), 0);
      bus_stop();
      gp_addr = 7'h30;
    end

    // R12: STOP mid-byte
    set_cfg(7'b1111110);
    stb_cnt = 0; pull_seen = 0;
    bus_start();
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h10 >> i));
    bus_stop();
    chk("R12", "mid stop pull", pull_seen, 0);
    chk("R12", "mid stop stb", stb_cnt, 0);

    // R12: repeated START after ACK clears flow and rw
    begin
      automatic logic a;
      set_cfg(7'b1111111);
      send_addr(8'h11, a);
      chk("R11", "pre-restart flow", int'(flow_sel), 1);
      chk("R11", "pre-restart rw", int'(rw_bit), 1);
      sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H);
      chk("R12", "restart flow", int'(flow_sel), 0);
      chk("R12", "restart rw", int'(rw_bit), 0);
      scl_m = 0; wt(2);
      for (int i = 7; i >= 0; i--) send_bit(1'(8'h55 >> i));
      wt(H);
      chk("R7", "after restart nack pull", int'(sda_pull), 0);
      bus_stop();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule